// File: doc/BRIEF.md
# Timer Channel with Selectable Counter Clear

This block is one channel of a 16-bit up-counting timer. A free-running counter advances on each count-enable pulse. It returns to zero when an event picked by a three-bit clear-select field occurs. The candidate events are a compare match or an input capture on one of four general registers (A, B, C, D), or a clear broadcast by another channel in the same synchronisation group. A single write port loads the control word, the counter and the general registers.

Several channels can form a group by wiring each channel's sync-clear output to the sync-clear input of its peers. A channel that clears from its own register event, and has its sync enable set, raises the sync-clear output in that cycle. Any peer that selects the synchronous option and has its own sync enable set clears on the same clock. A buffer-mode bit makes registers C and D inert, so they neither match nor capture. A parameter builds a reduced channel in which the top select bit does not exist.

Top module: `tmr_clrsel_chan`

## Requirements
- R1: After reset the counter is 0, the control word is 0 (clearing disabled), every general register holds 0xFFFF, and sync_clr_out is low.
- R2: When neither a write to the counter nor a clear occurs, each cycle with cnt_en high adds one to the counter, and 0xFFFF is followed by 0x0000.
- R3: The clear-select codes are 001 for register A, 010 for B, 101 for C and 110 for D. In compare mode, a cycle with cnt_en high and counter equal to the selected register loads 0 on that clock instead of incrementing, so the period is the register value plus one.
- R4: Codes 000 and 100 never clear the counter, even when it passes a register value.
- R5: Control bits 3 to 6 put registers A to D in capture mode. A rising edge on cap_in[i] copies the counter into register i on that clock and counts as that register's clear event. A register in capture mode makes no compare match.
- R6: sync_clr_out is high only in a cycle where the channel clears from its selected A, B, C or D event and control bit 7 (sync enable) is set.
- R7: Codes 011 and 111, with sync enable set, clear the counter on the clock where sync_clr_in is high. Without sync enable, sync_clr_in has no effect.
- R8: With control bit 8 (buffer mode) set, registers C and D make neither compare matches nor captures. Selecting C or D then never clears the counter, and cap_in[2] and cap_in[3] leave those registers unchanged.
- R9: With REDUCED set, bit 2 of the clear-select field always reads 0 and ignores writes.
- R10: A write to the counter (address 1) wins over a clear and a count in the same cycle. A write to a general register (addresses 4 to 7 for A to D) wins over a capture into it.
- R11: A write to address 0 loads data bits 8:0 into the control word: select in bits 2:0, capture modes in 6:3, sync enable in 7, buffer mode in 8. The word is read back on ctrl_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 control, 1 counter, 4..7 registers A..D |
| wr_data | input | 16 | Write data |
| cap_in | input | 4 | Capture inputs for registers A..D (rising edge) |
| sync_clr_in | input | 1 | Clear broadcast from peer channels |
| cnt_q | output | 16 | Counter value |
| ctrl_q | output | 9 | Control word readback |
| gr_q | output | 64 | Registers A..D, A in bits 15:0 |
| sync_clr_out | output | 1 | Clear broadcast to peer channels |

## Verification
Two collisions matter most. A counter write can land in the same cycle as a compare clear, and a register write can land in the same cycle as a capture edge on that register. Directed steps line up each pair on one clock, and the random phase also hits them because of its small value range. The result must show the written value in both cases. A second, reduced channel in sync mode is wired to the first. Each cycle the bench compares the two counters to show that the peer clears on the same clock as the source and stops following it once its sync enable is dropped.

// File: rtl/tmr_clrsel_pkg.sv
package tmr_clrsel_pkg;

  localparam int NUM_GR = 4;

  typedef enum logic [2:0] {
    CLR_OFF     = 3'b000,
    CLR_A       = 3'b001,
    CLR_B       = 3'b010,
    CLR_SYNC    = 3'b011,
    CLR_OFF_HI  = 3'b100,
    CLR_C       = 3'b101,
    CLR_D       = 3'b110,
    CLR_SYNC_HI = 3'b111
  } clr_sel_e;

  typedef struct packed {
    logic              buf_cd;
    logic              sync_en;
    logic [NUM_GR-1:0] cap_mode;
    clr_sel_e          clr_sel;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CNT  = 3'd1;

endpackage

// File: rtl/tmr_clrsel_gr.sv
module tmr_clrsel_gr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cnt,
  input  logic         cnt_en,
  input  logic         cap_mode,
  input  logic         cap_pin,
  input  logic         inhibit,
  output logic [W-1:0] val,
  output logic         evt
);

  logic pin_prev;
  logic cap_evt;
  logic cmp_evt;

  assign cap_evt = cap_mode && !inhibit && cap_pin && !pin_prev;
  assign cmp_evt = !cap_mode && !inhibit && cnt_en && (cnt == val);
  assign evt     = cap_evt | cmp_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_prev <= 1'b0;
      val      <= '1;
    end else begin
      pin_prev <= cap_pin;
      if (wr)
        val <= wdata;
      else if (cap_evt)
        val <= cnt;
    end
  end

endmodule

// File: rtl/tmr_clrsel_decode.sv
module tmr_clrsel_decode
  import tmr_clrsel_pkg::*;
(
  input  chan_ctrl_t        ctrl,
  input  logic [NUM_GR-1:0] gr_evt,
  input  logic              sync_in,
  output logic              own_clr,
  output logic              peer_clr
);

  always_comb begin
    unique case (ctrl.clr_sel)
      CLR_A:   own_clr = gr_evt[0];
      CLR_B:   own_clr = gr_evt[1];
      CLR_C:   own_clr = gr_evt[2];
      CLR_D:   own_clr = gr_evt[3];
      default: own_clr = 1'b0;
    endcase
  end

  always_comb begin
    peer_clr = 1'b0;
    if (ctrl.clr_sel == CLR_SYNC || ctrl.clr_sel == CLR_SYNC_HI)
      peer_clr = ctrl.sync_en && sync_in;
  end

endmodule

// File: rtl/tmr_clrsel_counter.sv
module tmr_clrsel_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (wr)
      cnt <= wdata;
    else if (clr)
      cnt <= '0;
    else if (en)
      cnt <= cnt + W'(1);
  end

endmodule

// File: rtl/tmr_clrsel_chan.sv
module tmr_clrsel_chan
  import tmr_clrsel_pkg::*;
#(
  parameter int W       = 16,
  parameter bit REDUCED = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnt_en,
  input  logic                wr_en,
  input  logic [2:0]          wr_addr,
  input  logic [W-1:0]        wr_data,
  input  logic [NUM_GR-1:0]   cap_in,
  input  logic                sync_clr_in,
  output logic [W-1:0]        cnt_q,
  output logic [CTRL_W-1:0]   ctrl_q,
  output logic [NUM_GR*W-1:0] gr_q,
  output logic                sync_clr_out
);

  localparam logic [CTRL_W-1:0] CTRL_MASK =
    REDUCED ? ~(CTRL_W'(1) << 2) : '1;

  chan_ctrl_t        ctrl_r;
  logic [W-1:0]      cnt;
  logic [NUM_GR-1:0] gr_evt;
  logic              own_clr;
  logic              peer_clr;
  logic              clr_any;
  logic              wr_cnt;
  logic              wr_ctrl;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_cnt  = wr_en && (wr_addr == ADDR_CNT);

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_r <= '0;
    else if (wr_ctrl)
      ctrl_r <= chan_ctrl_t'(wr_data[CTRL_W-1:0] & CTRL_MASK);
  end

  for (genvar i = 0; i < NUM_GR; i++) begin : g_gr
    localparam bit BUFFERABLE = (i >= NUM_GR - 2);
    logic wr_gr;
    assign wr_gr = wr_en && (wr_addr == {1'b1, 2'(i)});
    tmr_clrsel_gr #(.W(W)) gr_i (
      .clk      (clk),
      .rst      (rst),
      .wr       (wr_gr),
      .wdata    (wr_data),
      .cnt      (cnt),
      .cnt_en   (cnt_en),
      .cap_mode (ctrl_r.cap_mode[i]),
      .cap_pin  (cap_in[i]),
      .inhibit  (BUFFERABLE && ctrl_r.buf_cd),
      .val      (gr_q[i*W +: W]),
      .evt      (gr_evt[i])
    );
  end

  tmr_clrsel_decode dec_i (
    .ctrl     (ctrl_r),
    .gr_evt   (gr_evt),
    .sync_in  (sync_clr_in),
    .own_clr  (own_clr),
    .peer_clr (peer_clr)
  );

  assign clr_any = own_clr | peer_clr;

  tmr_clrsel_counter #(.W(W)) cnt_i (
    .clk   (clk),
    .rst   (rst),
    .wr    (wr_cnt),
    .wdata (wr_data),
    .clr   (clr_any),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  assign cnt_q        = cnt;
  assign ctrl_q       = ctrl_r;
  assign sync_clr_out = own_clr && ctrl_r.sync_en;

endmodule

// File: rtl/tmr_clrsel_chan_chk.sv
module tmr_clrsel_chan_chk #(
  parameter int W       = 16,
  parameter bit REDUCED = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         cnt_en,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] cnt_q,
  input logic [8:0]   ctrl_q,
  input logic         sync_clr_out,
  input logic         clr_any
);

  logic wr_cnt;
  assign wr_cnt = wr_en && (wr_addr == 3'd1);

  // R2: plain count step
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !wr_cnt && !clr_any) |=> (cnt_q == W'($past(cnt_q) + W'(1))));

  // R3: a clear lands as zero on the next state
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (clr_any && !wr_cnt) |=> (cnt_q == '0));

  // R10: counter write wins
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt_q == $past(wr_data)));

  // R4: disabled codes never clear
  a_r4_no_clear_off: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1:0] == 2'b00) |-> !clr_any);

  // R6: broadcast needs sync enable and an own source
  a_r6_sync_out_gated: assert property (@(posedge clk) disable iff (rst)
    sync_clr_out |-> (ctrl_q[7] && clr_any && ctrl_q[1:0] != 2'b11));

  // R7: synchronous code without enable never clears
  a_r7_sync_needs_en: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[1:0] == 2'b11 && !ctrl_q[7]) |-> !clr_any);

  // R8: buffered C/D never clear
  a_r8_buffer_inert: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[8] && (ctrl_q[2:0] == 3'b101 || ctrl_q[2:0] == 3'b110)) |-> !clr_any);

  // R9: reserved select bit in reduced channel
  a_r9_reduced_bit: assert property (@(posedge clk) disable iff (rst)
    REDUCED |-> !ctrl_q[2]);

endmodule

bind tmr_clrsel_chan tmr_clrsel_chan_chk #(.W(W), .REDUCED(REDUCED)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cnt_en       (cnt_en),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .cnt_q        (cnt_q),
  .ctrl_q       (ctrl_q),
  .sync_clr_out (sync_clr_out),
  .clr_any      (clr_any)
);

// File: tb/tmr_clrsel_chan_tb_top.sv
`timescale 1ns/1ps
module tmr_clrsel_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  cap_in = '0;
  logic [15:0] cnt_q;
  logic [8:0]  ctrl_q;
  logic [63:0] gr_q;
  logic        sync_clr_out;

  logic        p_wr = 1'b0;
  logic [2:0]  p_addr = '0;
  logic [15:0] p_data = '0;
  logic [15:0] p_cnt;
  logic [8:0]  p_ctrl;
  logic [63:0] p_gr;
  logic        p_sync_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] m_cnt;
  logic [8:0]  m_ctrl;
  logic [15:0] m_gr [4];
  logic [3:0]  m_prev;

  always #10 clk = ~clk;

  tmr_clrsel_chan #(.W(16), .REDUCED(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cap_in(cap_in), .sync_clr_in(p_sync_out),
    .cnt_q(cnt_q), .ctrl_q(ctrl_q), .gr_q(gr_q), .sync_clr_out(sync_clr_out)
  );

  tmr_clrsel_chan #(.W(16), .REDUCED(1'b1)) peer_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(p_wr), .wr_addr(p_addr),
    .wr_data(p_data), .cap_in(4'b0000), .sync_clr_in(sync_clr_out),
    .cnt_q(p_cnt), .ctrl_q(p_ctrl), .gr_q(p_gr), .sync_clr_out(p_sync_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; cnt_en = 1'b0; cap_in = '0; p_wr = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst = 1'b0;
    m_cnt = '0; m_ctrl = '0; m_prev = '0;
    for (int i = 0; i < 4; i++) m_gr[i] = 16'hFFFF;
  endtask

  // One clock of stimulus, checked against the bench model.
  task automatic step(input string tag, input bit en, input bit wr,
                      input logic [2:0] a, input logic [15:0] d, input logic [3:0] cap);
    logic [3:0]  ev, capev;
    logic        own, peer, exp_sync;
    logic [15:0] n_cnt;
    logic [2:0]  sel;
    @(negedge clk);
    cnt_en = en; wr_en = wr; wr_addr = a; wr_data = d; cap_in = cap;
    #1;
    sel = m_ctrl[2:0];
    for (int i = 0; i < 4; i++) begin
      bit inh;
      bit capm;
      inh  = m_ctrl[8] && (i >= 2);
      capm = m_ctrl[3+i];
      capev[i] = capm && !inh && cap[i] && !m_prev[i];
      ev[i] = capev[i] || (!capm && !inh && en && (m_cnt == m_gr[i]));
    end
    own = (sel == 3'd1 && ev[0]) || (sel == 3'd2 && ev[1]) ||
          (sel == 3'd5 && ev[2]) || (sel == 3'd6 && ev[3]);
    peer = (sel[1:0] == 2'b11) && m_ctrl[7] && p_sync_out;
    exp_sync = own && m_ctrl[7];
    chk({tag, " R6 sync_out"}, 64'(sync_clr_out), 64'(exp_sync));
    if (wr && a == 3'd1)   n_cnt = d;
    else if (own || peer)  n_cnt = '0;
    else if (en)           n_cnt = m_cnt + 16'd1;
    else                   n_cnt = m_cnt;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (wr && a == {1'b1, 2'(i)}) m_gr[i] = d;
      else if (capev[i])            m_gr[i] = m_cnt;
    end
    if (wr && a == 3'd0) m_ctrl = d[8:0];
    m_cnt  = n_cnt;
    m_prev = cap;
    #5;
    chk({tag, " cnt"}, 64'(cnt_q), 64'(m_cnt));
    chk({tag, " R11 ctrl"}, 64'(ctrl_q), 64'(m_ctrl));
    chk({tag, " gr"}, gr_q, {m_gr[3], m_gr[2], m_gr[1], m_gr[0]});
    wr_en = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [15:0] d);
    step(tag, 1'b0, 1'b1, a, d, cap_in);
  endtask

  task automatic run(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag, 1'b1, 1'b0, 3'd0, 16'd0, cap_in);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    #1;
    // R1 reset values
    chk("R1 cnt", 64'(cnt_q), 64'h0);
    chk("R1 ctrl", 64'(ctrl_q), 64'h0);
    chk("R1 gr", gr_q, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1 sync_out", 64'(sync_clr_out), 64'h0);

    // R2 wrap
    wr("R2", 3'd1, 16'hFFFE);
    run("R2", 1);
    chk("R2 at top", 64'(cnt_q), 64'hFFFF);
    run("R2", 1);
    chk("R2 wrapped", 64'(cnt_q), 64'h0);

    // R3 compare on A, period A+1, with broadcast
    wr("R3", 3'd4, 16'd4);
    wr("R3", 3'd0, 16'h081);
    run("R3", 5);
    chk("R3 cleared after A", 64'(cnt_q), 64'h0);

    // R4 disabled code 100
    wr("R4", 3'd0, 16'h004);
    run("R4", 6);
    chk("R4 no clear", 64'(cnt_q), 64'd6);

    // R3 on register C
    wr("R3", 3'd1, 16'd0);
    wr("R3", 3'd6, 16'd2);
    wr("R3", 3'd0, 16'h005);
    run("R3", 3);
    chk("R3 C clear", 64'(cnt_q), 64'h0);

    // R8 buffered C: no compare, no capture
    wr("R8", 3'd0, 16'h105);
    run("R8", 4);
    chk("R8 no clear", 64'(cnt_q), 64'd4);
    wr("R8", 3'd0, 16'h125);
    step("R8", 1'b1, 1'b0, 3'd0, 16'd0, 4'b0100);
    chk("R8 C kept", 64'(gr_q[47:32]), 64'd2);
    chk("R8 cnt runs", 64'(cnt_q), 64'd5);
    step("R8", 1'b0, 1'b0, 3'd0, 16'd0, 4'b0000);

    // R5 capture on B clears and latches
    wr("R5", 3'd0, 16'h012);
    wr("R5", 3'd1, 16'h0050);
    step("R5", 1'b1, 1'b0, 3'd0, 16'd0, 4'b0010);
    chk("R5 B latched", 64'(gr_q[31:16]), 64'h50);
    chk("R5 cleared", 64'(cnt_q), 64'h0);
    step("R5", 1'b1, 1'b0, 3'd0, 16'd0, 4'b0010);
    chk("R5 level no edge", 64'(cnt_q), 64'h1);
    step("R5", 1'b0, 1'b0, 3'd0, 16'd0, 4'b0000);

    // R10 counter write against compare clear
    wr("R10", 3'd0, 16'h001);
    wr("R10", 3'd4, 16'd3);
    wr("R10", 3'd1, 16'd3);
    step("R10", 1'b1, 1'b1, 3'd1, 16'h0077, 4'b0000);
    chk("R10 cnt write wins", 64'(cnt_q), 64'h77);
    // R10 register write against capture
    wr("R10", 3'd0, 16'h008);
    step("R10", 1'b1, 1'b1, 3'd4, 16'h1234, 4'b0001);
    chk("R10 gr write wins", 64'(gr_q[15:0]), 64'h1234);
    step("R10", 1'b0, 1'b0, 3'd0, 16'd0, 4'b0000);

    // R11 full control readback
    wr("R11", 3'd0, 16'h01FF);
    chk("R11 readback", 64'(ctrl_q), 64'h1FF);

    // R9 / R7 with a reduced peer
    do_reset();
    p_wr = 1'b1; p_addr = 3'd0; p_data = 16'h085;
    step("R9", 1'b0, 1'b0, 3'd0, 16'd0, 4'b0000);
    p_wr = 1'b0;
    chk("R9 reserved bit", 64'(p_ctrl), 64'h081);
    p_wr = 1'b1; p_data = 16'h083;
    step("R7", 1'b0, 1'b0, 3'd0, 16'd0, 4'b0000);
    p_wr = 1'b0;
    wr("R7", 3'd4, 16'd5);
    wr("R7", 3'd0, 16'h081);
    for (int k = 0; k < 12; k++) begin
      run("R7", 1);
      chk("R7 peer follows", 64'(p_cnt), 64'(cnt_q));
    end
    chk("R7 both zero", 64'(p_cnt), 64'h0);
    p_wr = 1'b1; p_data = 16'h003;
    step("R7", 1'b0, 1'b0, 3'd0, 16'd0, 4'b0000);
    p_wr = 1'b0;
    run("R7", 12);
    chk("R7 ignored without enable", 64'(p_cnt), 64'd12);
    chk("R7 source period", 64'(cnt_q), 64'h0);

    // Random mix
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      bit          en, w;
      logic [2:0]  a;
      logic [15:0] d;
      logic [3:0]  cap;
      en = ($urandom_range(0, 3) != 0);
      w  = ($urandom_range(0, 7) == 0);
      case ($urandom_range(0, 5))
        0:       a = 3'd0;
        1:       a = 3'd1;
        default: a = 3'($urandom_range(4, 7));
      endcase
      d = (a == 3'd0) ? 16'($urandom_range(0, 511)) : 16'($urandom_range(0, 24));
      cap = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
      step("R2 R3 R5 R8 R10 random", en, w, a, d, cap);
    end

    done = 1'b1;
    finish_run();
  end

endmodule